// File: doc/BRIEF.md
# Submission Queue Fetch Controller

This block is the host-side engine behind one circular submission queue. Software writes 32-byte command entries into a small internal entry store. It then moves the tail pointer forward. Whenever the queue is running and not empty, the block fetches the entry at the head and presents it on a valid/ready output. The head then advances, and each slot index wraps with a power-of-two mask.

Software controls the queue through a register port. It can halt fetching and resume it. While the queue is halted, it can ask the block to cancel one queued command. The command is named by its logical unit and its task tag. The block finds the command by walking from head to tail, one slot per cycle. It marks the command with a reserved command-type code, and the fetcher then drops that entry instead of issuing it. A status word reports three things: whether fetching has halted, whether a cancel has finished, and a result code for the cancel.

Top module: `sqf_top`

## Requirements
- R1: After reset, head and tail both read 0, the status word reads 0 and `ent_valid` is low.
- R2: Head (0x000) and tail (0x004) hold byte offsets, and slot = offset / 32. Writing the tail register sets the tail slot. While the queue is running and head differs from tail, the entries are issued on the output in slot order. Each issued entry advances the head. The queue is empty when head equals tail.
- R3: While `ent_valid` is high and `ent_ready` is low, `ent_valid` stays high and `ent_data` stays unchanged.
- R4: An entry whose dword 0 bits 31:28 equal 0xF is never issued. The head still steps past it.
- R5: Slot indices wrap modulo the queue depth, which is a power of two.
- R6: Writing 0x1 to the control register (0x008) requests a halt. Status bit 0 (register 0x010) becomes 1 only once no entry is pending on the output. After that, no entry is fetched and the head does not move.
- R7: Writing 0x0 to the control register clears status bit 0 and resumes fetching.
- R8: Writing 0x2 to the control register while halted starts a cancel. The block searches head to tail for the entry whose dword 0 bits 15:0 equal the target register (0x00C: LUN in bits 15:8, task tag in bits 7:0). It sets that entry's bits 31:28 to 0xF. When the cancel ends, status bit 1 is set and the result code in status bits 7:4 is 0.
- R9: If no entry between head and tail matches, the cancel ends with status bit 1 set and result code 2.
- R10: A cancel request made while the queue is not halted sets status bit 1 and result code 1 on the next cycle, and touches no entry.
- R11: Entry dword d of slot s is written at address 0x800 + 32*s + 4*d. Dword d occupies bits 32d+31:32d of `ent_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register or entry-store write strobe |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ent_valid | output | 1 | Fetched entry is presented |
| ent_ready | input | 1 | Consumer accepts the entry |
| ent_data | output | 256 | Fetched 32-byte entry |

## Verification
A wrong head or tail shows up at once at the output: an entry is missing, repeated or out of order, and the scoreboard catches it on the next handshake. It also shows in the readable head offset after the queue drains. A halt flag that rises too early would show an entry stranded on the output while status says halted. A cancel that marks the wrong slot would let the target entry through after restart, or swallow its neighbour. Either case shows as a scoreboard mismatch within a few cycles of resuming.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
    localparam int ENTRY_BITS = 256;
    localparam int ADDR_W     = 12;

    localparam logic [ADDR_W-1:0] A_HEAD   = 12'h000;
    localparam logic [ADDR_W-1:0] A_TAIL   = 12'h004;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] A_TARGET = 12'h00C;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h010;

    localparam logic [31:0] CMD_RUN   = 32'h0;
    localparam logic [31:0] CMD_HALT  = 32'h1;
    localparam logic [31:0] CMD_PURGE = 32'h2;

    localparam logic [3:0] RES_OK      = 4'd0;
    localparam logic [3:0] RES_RUNNING = 4'd1;
    localparam logic [3:0] RES_MISSING = 4'd2;

    localparam logic [3:0] TYPE_VOID = 4'hF;
endpackage

// File: rtl/sqf_entry_mem.sv
module sqf_entry_mem #(
    parameter int DEPTH = 8,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_slot,
    input  logic [2:0]      wr_dword,
    input  logic [31:0]     wr_data,
    input  logic            void_en,
    input  logic [IDXW-1:0] void_slot,
    input  logic [IDXW-1:0] rd_a_slot,
    output logic [255:0]    rd_a_data,
    input  logic [IDXW-1:0] rd_b_slot,
    output logic [255:0]    rd_b_data
);
    import sqf_pkg::*;

    logic [255:0] rows [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [255:0] row_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else begin
                if (wr_en && wr_slot == IDXW'(s))
                    row_q[{wr_dword, 5'b0} +: 32] <= wr_data;
                if (void_en && void_slot == IDXW'(s))
                    row_q[31:28] <= TYPE_VOID;
            end
        end
        assign rows[s] = row_q;
    end

    assign rd_a_data = rows[rd_a_slot];
    assign rd_b_data = rows[rd_b_slot];
endmodule

// File: rtl/sqf_ctrl.sv
module sqf_ctrl #(
    parameter int DEPTH = 8,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_en,
    input  logic [11:0]     reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic            ent_ready,
    input  logic [255:0]    head_data,
    input  logic [255:0]    scan_data,
    output logic [IDXW-1:0] head_idx,
    output logic [IDXW-1:0] tail_idx,
    output logic [IDXW-1:0] scan_idx,
    output logic            void_en,
    output logic            ent_valid,
    output logic [255:0]    ent_data,
    output logic            sts_halted,
    output logic            sts_done,
    output logic [3:0]      sts_code,
    output logic [15:0]     target
);
    import sqf_pkg::*;

    typedef struct packed {
        logic [IDXW-1:0] head;
        logic [IDXW-1:0] tail;
        logic [IDXW-1:0] scan;
        logic            halt_req;
        logic            halted;
        logic            busy;
        logic            done;
        logic [3:0]      code;
        logic [15:0]     target;
        logic            out_valid;
        logic [255:0]    out_data;
    } st_t;

    st_t st_q, st_d;
    logic running;

    always_comb begin
        st_d    = st_q;
        void_en = 1'b0;
        running = !st_q.halt_req && !st_q.halted && !st_q.busy;

        if (st_q.out_valid && ent_ready)
            st_d.out_valid = 1'b0;

        if (st_q.halt_req && !st_q.halted && !st_q.out_valid)
            st_d.halted = 1'b1;

        if (running && !st_q.out_valid && st_q.head != st_q.tail) begin
            st_d.head = st_q.head + 1'b1;
            if (head_data[31:28] != TYPE_VOID) begin
                st_d.out_valid = 1'b1;
                st_d.out_data  = head_data;
            end
        end

        if (st_q.busy) begin
            if (st_q.scan == st_q.tail) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.code = RES_MISSING;
            end else if (scan_data[15:0] == st_q.target) begin
                void_en   = 1'b1;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.code = RES_OK;
            end else begin
                st_d.scan = st_q.scan + 1'b1;
            end
        end

        if (reg_wr_en) begin
            if (reg_addr == A_TAIL)
                st_d.tail = reg_wdata[IDXW+4:5];
            if (reg_addr == A_TARGET)
                st_d.target = reg_wdata[15:0];
            if (reg_addr == A_CTRL && !st_q.busy) begin
                if (reg_wdata == CMD_HALT) begin
                    st_d.halt_req = 1'b1;
                end else if (reg_wdata == CMD_RUN) begin
                    st_d.halt_req = 1'b0;
                    st_d.halted   = 1'b0;
                end else if (reg_wdata == CMD_PURGE) begin
                    if (st_q.halted) begin
                        st_d.busy = 1'b1;
                        st_d.done = 1'b0;
                        st_d.scan = st_q.head;
                        st_d.code = RES_OK;
                    end else begin
                        st_d.done = 1'b1;
                        st_d.code = RES_RUNNING;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_idx   = st_q.head;
    assign tail_idx   = st_q.tail;
    assign scan_idx   = st_q.scan;
    assign ent_valid  = st_q.out_valid;
    assign ent_data   = st_q.out_data;
    assign sts_halted = st_q.halted;
    assign sts_done   = st_q.done;
    assign sts_code   = st_q.code;
    assign target     = st_q.target;
endmodule

// File: rtl/sqf_top.sv
module sqf_top #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr_en,
    input  logic [11:0]  reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    output logic         ent_valid,
    input  logic         ent_ready,
    output logic [255:0] ent_data
);
    import sqf_pkg::*;

    logic [IDXW-1:0] head_idx, tail_idx, scan_idx;
    logic            void_en;
    logic [255:0]    head_data, scan_data;
    logic            sts_halted, sts_done;
    logic [3:0]      sts_code;
    logic [15:0]     target;
    logic            mem_wr;

    assign mem_wr = reg_wr_en && reg_addr[11];

    sqf_entry_mem #(.DEPTH(DEPTH), .IDXW(IDXW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mem_wr),
        .wr_slot   (reg_addr[IDXW+4:5]),
        .wr_dword  (reg_addr[4:2]),
        .wr_data   (reg_wdata),
        .void_en   (void_en),
        .void_slot (scan_idx),
        .rd_a_slot (head_idx),
        .rd_a_data (head_data),
        .rd_b_slot (scan_idx),
        .rd_b_data (scan_data)
    );

    sqf_ctrl #(.DEPTH(DEPTH), .IDXW(IDXW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .ent_ready  (ent_ready),
        .head_data  (head_data),
        .scan_data  (scan_data),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .scan_idx   (scan_idx),
        .void_en    (void_en),
        .ent_valid  (ent_valid),
        .ent_data   (ent_data),
        .sts_halted (sts_halted),
        .sts_done   (sts_done),
        .sts_code   (sts_code),
        .target     (target)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_HEAD:   reg_rdata = {{(27-IDXW){1'b0}}, head_idx, 5'b0};
            A_TAIL:   reg_rdata = {{(27-IDXW){1'b0}}, tail_idx, 5'b0};
            A_TARGET: reg_rdata = {16'b0, target};
            A_STATUS: reg_rdata = {24'b0, sts_code, 2'b0, sts_done, sts_halted};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sqf_chk.sv
module sqf_chk #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ent_valid,
    input logic            ent_ready,
    input logic [255:0]    ent_data,
    input logic            halted,
    input logic [IDXW-1:0] head,
    input logic [IDXW-1:0] tail
);
    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && !ent_ready |=> ent_valid && $stable(ent_data)); // R3
    AST_NO_VOID_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> ent_data[31:28] != 4'hF); // R4
    AST_HALT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> !ent_valid); // R6
    AST_HEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(head)); // R6
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (head == tail) && !ent_valid |=> !ent_valid); // R2
endmodule

bind sqf_top sqf_chk #(.IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (ent_valid),
    .ent_ready (ent_ready),
    .ent_data  (ent_data),
    .halted    (sts_halted),
    .head      (head_idx),
    .tail      (tail_idx)
);

// File: tb/tb_sqf_top.sv
module tb_sqf_top;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         ent_valid;
    logic         ent_ready = 1'b0;
    logic [255:0] ent_data;

    int n_run = 0;
    int n_fail = 0;
    logic [255:0] exp_q [$];
    logic auto_rdy = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    sqf_top dut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk(input logic [7:0] lun, input logic [7:0] tag,
                                        input logic [3:0] ty);
        logic [255:0] e;
        e[31:0] = {ty, 12'h0, lun, tag};
        for (int d = 1; d < 8; d++) e[d*32 +: 32] = {tag ^ 8'h3C, 8'(d), lun, tag};
        return e;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a; #1;
        v = reg_rdata;
    endtask

    task automatic put(input int slot, input logic [255:0] e, input bit expect_out);
        for (int d = 0; d < 8; d++) wr(12'(12'h800 + slot*32 + d*4), e[d*32 +: 32]);
        if (expect_out) exp_q.push_back(e);
    endtask

    // random ready while auto_rdy is set
    always @(posedge clk) if (auto_rdy) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ent_ready = lfsr[0] | lfsr[2];
    end

    // monitor: scoreboard compare and hold check
    logic         pv = 1'b0, pr = 1'b0;
    logic [255:0] pd = '0;
    always @(negedge clk) if (rst_n) begin
        if (pv && !pr) begin
            n_run++;
            if (!ent_valid || ent_data !== pd) begin
                n_fail++;
                $display("FAIL R3 actual=%b/%h expected=1/%h", ent_valid, ent_data[31:0], pd[31:0]);
            end
        end
        if (ent_valid && ent_ready) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 R4 actual=%h expected=none", ent_data[31:0]);
            end else begin
                logic [255:0] e;
                e = exp_q.pop_front();
                if (ent_data !== e) begin
                    n_fail++;
                    $display("FAIL R2 R11 actual=%h expected=%h", ent_data, e);
                end
            end
        end
        pv = ent_valid; pr = ent_ready; pd = ent_data;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk); #1;
        rd(12'h010, v); check("R1 status", v, 32'h0);
        rd(12'h000, v); check("R1 head", v, 32'h0);
        rd(12'h004, v); check("R1 tail", v, 32'h0);
        check("R1 valid", 32'(ent_valid), 32'h0);
        rst_n = 1'b1;
        auto_rdy = 1'b1;

        // R2 R11: plain in-order issue
        put(0, mk(8'h01, 8'h10, 4'h1), 1);
        put(1, mk(8'h02, 8'h11, 4'h2), 1);
        put(2, mk(8'h03, 8'h12, 4'h1), 1);
        wr(12'h004, 32'h60);
        rd(12'h004, v); check("R2 tail", v, 32'h60);
        repeat (40) @(posedge clk); #1;
        rd(12'h000, v); check("R2 head", v, 32'h60);
        check("R2 drained", 32'(exp_q.size()), 0);

        // R4: nullified entry skipped
        put(3, mk(8'h04, 8'h20, 4'h1), 1);
        put(4, mk(8'h05, 8'h21, 4'hF), 0);
        put(5, mk(8'h06, 8'h22, 4'h3), 1);
        wr(12'h004, 32'hC0);
        repeat (40) @(posedge clk); #1;
        rd(12'h000, v); check("R4 head", v, 32'hC0);
        check("R4 drained", 32'(exp_q.size()), 0);

        // R5: wrap
        put(6, mk(8'h07, 8'h30, 4'h1), 1);
        put(7, mk(8'h08, 8'h31, 4'h1), 1);
        put(0, mk(8'h09, 8'h32, 4'h1), 1);
        put(1, mk(8'h0A, 8'h33, 4'h1), 1);
        wr(12'h004, 32'h40);
        repeat (50) @(posedge clk); #1;
        rd(12'h000, v); check("R5 head", v, 32'h40);
        check("R5 drained", 32'(exp_q.size()), 0);

        // R6: halt waits for pending output
        auto_rdy = 1'b0;
        @(posedge clk); #2; ent_ready = 1'b0;
        put(2, mk(8'h0B, 8'h40, 4'h1), 1);
        put(3, mk(8'h0C, 8'h41, 4'h1), 1);
        put(4, mk(8'h0D, 8'h42, 4'h1), 0);
        wr(12'h004, 32'hA0);
        repeat (3) @(posedge clk); #1;
        wr(12'h008, 32'h1);
        repeat (5) @(posedge clk); #1;
        rd(12'h010, v); check("R6 pending", v, 32'h0);
        ent_ready = 1'b1;
        @(posedge clk); #1; ent_ready = 1'b0;
        repeat (3) @(posedge clk); #1;
        rd(12'h010, v); check("R6 halted", v, 32'h1);
        ent_ready = 1'b1;
        repeat (8) @(posedge clk); #1;
        rd(12'h000, v); check("R6 head frozen", v, 32'h60);
        check("R6 nothing issued", 32'(ent_valid), 0);

        // R8: cancel tag 0x42 on LUN 0x0D (slot 4)
        wr(12'h00C, 32'h0D42);
        wr(12'h008, 32'h2);
        repeat (10) @(posedge clk); #1;
        rd(12'h010, v); check("R8 status", v, 32'h03);
        wr(12'h008, 32'h0);
        #1; rd(12'h010, v); check("R7 resumed", v & 32'h1, 32'h0);
        repeat (20) @(posedge clk); #1;
        rd(12'h000, v); check("R8 head", v, 32'hA0);
        check("R8 R7 drained", 32'(exp_q.size()), 0);

        // R9: cancel with no match
        wr(12'h008, 32'h1);
        repeat (3) @(posedge clk); #1;
        wr(12'h00C, 32'h0977);
        wr(12'h008, 32'h2);
        repeat (10) @(posedge clk); #1;
        rd(12'h010, v); check("R9 status", v, 32'h23);

        // R10: cancel while running
        wr(12'h008, 32'h0);
        repeat (3) @(posedge clk); #1;
        wr(12'h008, 32'h2);
        rd(12'h010, v); check("R10 status", v, 32'h12);

        repeat (5) @(posedge clk); #1;
        check("R2 final empty", 32'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule